// File: doc/BRIEF.md
# Double-Edge Pixel Demultiplexer with Staged Channel Registers

This block takes a stream of 10-bit pixel codes from one shared bus and spreads them over twelve channel registers. A start strobe, sampled on the rising clock edge, opens a load cycle. That cycle lasts six clock periods and takes one word on every rising edge and one on every falling edge, so twelve words arrive in each cycle. The words are written into the channels in ascending or descending order, chosen by a direction input.

Each channel has two register stages. The load stage is filled one word at a time. At the next start strobe, every output register is updated from its load stage in a single edge. A polarity flag travels with the output stage. The invert input is captured when one cycle begins and is shown only at the following transfer. Each channel presents both the raw held code and its complement against full scale, which downstream drive logic uses. A transfer pulse marks each parallel update.

A new strobe may arrive before a cycle has finished. In that case the channels already loaded carry their new words, the others keep their older contents, and loading restarts from the first channel of the newly chosen direction.

Top module: `pixld_top`

## Requirements
- R1: A synchronous reset clears every load and output register to 0, so every held code reads 0 and every drive code reads 1023. Polarity and the transfer pulse both read 0. No load cycle runs until the first strobe, so pixel words presented before that strobe never reach a channel.
- R2: `xfrIn` is sampled on each rising edge. On the next rising edge after it is seen high, all twelve held codes update at once from the load stage, and a new load cycle begins with the word present at that edge.
- R3: A load cycle covers six clock periods. It takes the word at each rising edge as an even slot (0, 2, ... 10) and the word at each following falling edge as the next odd slot, for twelve words in total.
- R4: With `dirIn` low at cycle start, slot k is written to channel k (channel 0 occupies bits 9:0 of the packed outputs).
- R5: With `dirIn` high at cycle start, slot k is written to channel 11-k.
- R6: `dirIn` is sampled only on the edge that starts a cycle. Changing it later in the cycle has no effect on where the remaining words land.
- R7: `invIn` is captured on the edge that starts a cycle. `polarity` takes that value at the transfer that ends the cycle, one transfer later than the capture.
- R8: `xferPulse` is high for exactly the clock period that follows each transfer edge, and low otherwise.
- R9: For each channel, the drive code equals 1023 minus the held code.
- R10: If the strobe is seen again before six clocks have passed, the transfer still occurs. The channels loaded so far show their new words and the rest keep their previous load-stage contents. The new cycle restarts at the first channel.
- R11: Held codes and polarity change only on a transfer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; words are taken on both edges |
| rst | input | 1 | Synchronous active-high reset |
| pixIn | input | 10 | Pixel code, bit 9 is the MSB |
| xfrIn | input | 1 | Start/transfer strobe |
| dirIn | input | 1 | Load direction: 0 ascending, 1 descending |
| invIn | input | 1 | Polarity request |
| heldFlat | output | 120 | Twelve held codes, channel c at bits c*10+9:c*10 |
| driveFlat | output | 120 | Twelve drive codes (1023 minus held), same packing |
| polarity | output | 1 | Polarity flag associated with the held codes |
| xferPulse | output | 1 | One-cycle marker after each transfer |

## Verification
The bench builds the block with its default 10-bit words and twelve channels. With these values the ascending and descending channel orders are both distinct and easy to check. They also allow an early restart halfway through a cycle, which leaves six channels new and six old, so a misplaced boundary shows up clearly. Distinct word values per slot let every mis-steered word be traced to its slot.

// File: rtl/pixld_pkg.sv
package pixld_pkg;
  // width of the pair index carried from control to datapath; covers up to 512 channels
  localparam int IDX_BITS = 8;

  typedef struct packed {
    logic                writePair;  // a rise/fall word pair lands in the load stage this edge
    logic [IDX_BITS-1:0] pairIdx;    // which pair of the cycle is being written
    logic                dirHigh;    // descending order for the running cycle
    logic                transfer;   // copy load stage into output stage this edge
  } seq_ctl_t;
endpackage

// File: rtl/pixld_ctrl.sv
module pixld_ctrl #(
  parameter int NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfrIn,
  input  logic                dirIn,
  input  logic                invIn,
  output pixld_pkg::seq_ctl_t seqCtl,
  output logic                polarity,
  output logic                xferPulse
);
  localparam int PAIRS = NUM_CH / 2;
  localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(PAIRS - 1);

  logic             xfrSeen;
  logic             active;
  logic [CNT_W-1:0] pairCnt;
  logic             dirLatched;
  logic             invPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfrSeen    <= 1'b0;
      xferPulse  <= 1'b0;
      active     <= 1'b0;
      pairCnt    <= '0;
      dirLatched <= 1'b0;
      invPend    <= 1'b0;
      polarity   <= 1'b0;
    end else begin
      xfrSeen   <= xfrIn;
      xferPulse <= xfrSeen;
      if (xfrSeen) begin
        active     <= 1'b1;
        pairCnt    <= '0;
        dirLatched <= dirIn;
        polarity   <= invPend;
        invPend    <= invIn;
      end else if (active) begin
        if (pairCnt == LAST_PAIR) begin
          active <= 1'b0;
        end else begin
          pairCnt <= pairCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    seqCtl.writePair = active;
    seqCtl.pairIdx   = pixld_pkg::IDX_BITS'(pairCnt);
    seqCtl.dirHigh   = dirLatched;
    seqCtl.transfer  = xfrSeen;
  end
endmodule

// File: rtl/pixld_dpath.sv
module pixld_dpath #(
  parameter int PIX_W  = 10,
  parameter int NUM_CH = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PIX_W-1:0]          pixIn,
  input  pixld_pkg::seq_ctl_t       seqCtl,
  output logic [NUM_CH*PIX_W-1:0]   heldFlat,
  output logic [NUM_CH*PIX_W-1:0]   driveFlat
);
  localparam int IDXW = pixld_pkg::IDX_BITS;
  localparam logic [PIX_W-1:0] MAX_CODE = '1;

  logic [PIX_W-1:0] riseHold;
  logic [PIX_W-1:0] fallReg;

  always_ff @(posedge clk) begin
    if (rst) riseHold <= '0;
    else     riseHold <= pixIn;
  end

  always_ff @(negedge clk) begin
    if (rst) fallReg <= '0;
    else     fallReg <= pixIn;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int UP_PAIR = c / 2;
    localparam int UP_ODD  = c % 2;
    localparam int DN_PAIR = (NUM_CH - 1 - c) / 2;
    localparam int DN_ODD  = (NUM_CH - 1 - c) % 2;

    logic [PIX_W-1:0] loadReg;
    logic [PIX_W-1:0] nextVal;
    logic [PIX_W-1:0] outReg;
    logic             hitUp;
    logic             hitDn;

    always_comb begin
      hitUp   = !seqCtl.dirHigh && (seqCtl.pairIdx == IDXW'(UP_PAIR));
      hitDn   =  seqCtl.dirHigh && (seqCtl.pairIdx == IDXW'(DN_PAIR));
      nextVal = loadReg;
      if (seqCtl.writePair && hitUp) nextVal = (UP_ODD == 1) ? fallReg : riseHold;
      if (seqCtl.writePair && hitDn) nextVal = (DN_ODD == 1) ? fallReg : riseHold;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        loadReg <= '0;
        outReg  <= '0;
      end else begin
        loadReg <= nextVal;
        if (seqCtl.transfer) outReg <= nextVal;
      end
    end

    assign heldFlat[c*PIX_W +: PIX_W]  = outReg;
    assign driveFlat[c*PIX_W +: PIX_W] = MAX_CODE - outReg;
  end
endmodule

// File: rtl/pixld_top.sv
module pixld_top #(
  parameter int PIX_W  = 10,
  parameter int NUM_CH = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PIX_W-1:0]        pixIn,
  input  logic                    xfrIn,
  input  logic                    dirIn,
  input  logic                    invIn,
  output logic [NUM_CH*PIX_W-1:0] heldFlat,
  output logic [NUM_CH*PIX_W-1:0] driveFlat,
  output logic                    polarity,
  output logic                    xferPulse
);
  pixld_pkg::seq_ctl_t seqCtl;

  pixld_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .xfrIn(xfrIn), .dirIn(dirIn), .invIn(invIn),
    .seqCtl(seqCtl), .polarity(polarity), .xferPulse(xferPulse)
  );

  pixld_dpath #(.PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_dpath (
    .clk(clk), .rst(rst), .pixIn(pixIn), .seqCtl(seqCtl),
    .heldFlat(heldFlat), .driveFlat(driveFlat)
  );
endmodule

// File: rtl/pixld_chk.sv
module pixld_chk #(
  parameter int PIX_W  = 10,
  parameter int NUM_CH = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    xfrIn,
  input logic                    xferPulse,
  input logic                    polarity,
  input logic [NUM_CH*PIX_W-1:0] heldFlat,
  input pixld_pkg::seq_ctl_t     seqCtl
);
  localparam int PAIRS = NUM_CH / 2;
  localparam int IDXW  = pixld_pkg::IDX_BITS;

  // R8: a pulse is only ever caused by a strobe sampled two edges earlier
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    xferPulse |-> $past(xfrIn, 2));

  // R11: held codes move only on a transfer edge
  a_r11_held_quiet: assert property (@(posedge clk) disable iff (rst)
    !xferPulse |-> $stable(heldFlat));

  // R7: polarity moves only on a transfer edge
  a_r7_pol_quiet: assert property (@(posedge clk) disable iff (rst)
    !xferPulse |-> $stable(polarity));

  // R3: the cycle ends after its sixth pair unless a new strobe restarts it
  a_r3_cycle_ends: assert property (@(posedge clk) disable iff (rst)
    (seqCtl.writePair && seqCtl.pairIdx == IDXW'(PAIRS - 1) && !seqCtl.transfer)
      |=> !seqCtl.writePair);

  // R6: the load order stays fixed while a cycle continues
  a_r6_dir_held: assert property (@(posedge clk) disable iff (rst)
    (seqCtl.writePair && seqCtl.pairIdx != IDXW'(PAIRS - 1) && !seqCtl.transfer)
      |=> (seqCtl.writePair && $stable(seqCtl.dirHigh)));
endmodule

bind pixld_top pixld_chk #(.PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .xfrIn(xfrIn), .xferPulse(xferPulse),
  .polarity(polarity), .heldFlat(heldFlat), .seqCtl(seqCtl)
);

// File: tb/sim_pixld_top.sv
module sim_pixld_top;
  localparam int W  = 10;
  localparam int CH = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  pixIn = '0;
  logic          xfrIn = 1'b0;
  logic          dirIn = 1'b0;
  logic          invIn = 1'b0;
  logic [CH*W-1:0] heldFlat;
  logic [CH*W-1:0] driveFlat;
  logic          polarity;
  logic          xferPulse;

  int  nCmp = 0;
  int  nBad = 0;
  bit  started = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pixld_top u0 (
    .clk(clk), .rst(rst), .pixIn(pixIn), .xfrIn(xfrIn), .dirIn(dirIn), .invIn(invIn),
    .heldFlat(heldFlat), .driveFlat(driveFlat), .polarity(polarity), .xferPulse(xferPulse)
  );

  function automatic int heldAt(int c);
    return int'(heldFlat[c*W +: W]);
  endfunction

  function automatic int driveAt(int c);
    return int'(driveFlat[c*W +: W]);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mLoad[CH];
  int mOut[CH];
  int mSlot = -1;
  bit mDir = 0, mInvPend = 0, mPol = 0, mPulse = 0, mXfrPrev = 0;

  function automatic int chOf(int slot, bit d);
    return d ? (CH - 1 - slot) : slot;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mLoad[i]) begin mLoad[i] = 0; mOut[i] = 0; end
      mSlot = -1; mDir = 0; mInvPend = 0; mPol = 0; mPulse = 0; mXfrPrev = 0;
    end else begin
      mPulse = mXfrPrev;
      if (mXfrPrev) begin
        mOut = mLoad;
        mPol = mInvPend;
        mInvPend = invIn;
        mDir = dirIn;
        mSlot = 0;
      end
      if (mSlot >= 0 && mSlot < CH && (mSlot % 2) == 0) begin
        mLoad[chOf(mSlot, mDir)] = int'(pixIn);
        mSlot++;
      end
      mXfrPrev = xfrIn;
    end
  end

  always @(negedge clk) begin
    if (!rst && mSlot >= 1 && (mSlot % 2) == 1) begin
      mLoad[chOf(mSlot, mDir)] = int'(pixIn);
      mSlot++;
      if (mSlot >= CH) mSlot = -1;
    end
  end

  // every clock: compare all outputs with the model
  always begin
    @(negedge clk);
    #3;
    if (started && !rst) begin
      for (int c = 0; c < CH; c++) begin
        chk("R2", $sformatf("model held ch%0d", c), heldAt(c), mOut[c]);
        chk("R9", $sformatf("model drive ch%0d", c), driveAt(c), 1023 - mOut[c]);
      end
      chk("R7", "model polarity", int'(polarity), int'(mPol));
      chk("R8", "model pulse", int'(xferPulse), int'(mPulse));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wordCycle(int r, int f, bit x, bit d, bit iv);
    pixIn = W'(r); xfrIn = x; dirIn = d; invIn = iv;
    @(posedge clk);
    #2;
    pixIn = W'(f);
    @(negedge clk);
    #2;
  endtask

  task automatic afterStart(int phase);
    case (phase)
      0: begin
        for (int c = 0; c < CH; c++) chk("R1", $sformatf("no preload ch%0d", c), heldAt(c), 0);
        chk("R8", "pulse after transfer", int'(xferPulse), 1);
      end
      1: begin
        for (int c = 0; c < CH; c++) chk("R4", $sformatf("ascending ch%0d", c), heldAt(c), 100 + c);
        chk("R7", "polarity from first capture", int'(polarity), 1);
        chk("R2", "transfer pulse", int'(xferPulse), 1);
      end
      2: begin
        for (int k = 0; k < CH; k++) chk("R5", $sformatf("descending slot%0d", k), heldAt(CH-1-k), 200 + k);
        for (int c = 0; c < CH; c++) chk("R9", $sformatf("drive ch%0d", c), driveAt(c), 1023 - heldAt(c));
        chk("R7", "polarity second", int'(polarity), 0);
      end
      3: begin
        for (int c = 0; c < CH; c++) chk("R6", $sformatf("dir change ignored ch%0d", c), heldAt(c), 300 + c);
      end
      4: begin
        for (int c = 0; c < CH/2; c++) chk("R10", $sformatf("early new ch%0d", c), heldAt(c), 400 + c);
        for (int c = CH/2; c < CH; c++) chk("R10", $sformatf("early kept ch%0d", c), heldAt(c), 300 + c);
      end
      default: ;
    endcase
  endtask

  task automatic runSeq(int phase, int base, int nCyc, bit dFirst, bit dRest, bit iv, bit xLast);
    for (int i = 0; i < nCyc; i++) begin
      wordCycle(base + 2*i, base + 2*i + 1, xLast && (i == nCyc - 1), (i == 0) ? dFirst : dRest, iv);
      if (i == 0) afterStart(phase);
      if (i == 1) chk("R8", "pulse one cycle only", int'(xferPulse), 0);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    rst = 1'b0;
    started = 1'b1;
    for (int c = 0; c < CH; c++) begin
      chk("R1", $sformatf("reset held ch%0d", c), heldAt(c), 0);
      chk("R1", $sformatf("reset drive ch%0d", c), driveAt(c), 1023);
    end
    chk("R1", "reset polarity", int'(polarity), 0);
    chk("R1", "reset pulse", int'(xferPulse), 0);

    // words with no strobe: must not be loaded
    for (int i = 0; i < 4; i++) wordCycle(900 + i, 950 + i, 1'b0, 1'b0, 1'b0);
    wordCycle(0, 0, 1'b1, 1'b0, 1'b0);

    runSeq(0, 100, 6, 1'b0, 1'b0, 1'b1, 1'b1);   // ascending
    runSeq(1, 200, 6, 1'b1, 1'b1, 1'b0, 1'b1);   // descending
    runSeq(2, 300, 6, 1'b0, 1'b1, 1'b1, 1'b1);   // dir toggles mid-cycle
    runSeq(3, 400, 3, 1'b0, 1'b0, 1'b0, 1'b1);   // early restart
    runSeq(4, 500, 6, 1'b0, 1'b0, 1'b1, 1'b1);   // full cycle after restart

    wordCycle(0, 0, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < CH; c++) chk("R10", $sformatf("restart from first ch%0d", c), heldAt(c), 500 + c);
    chk("R3", "twelfth word landed", heldAt(CH-1), 511);

    for (int i = 0; i < 4; i++) wordCycle(700 + i, 750 + i, 1'b0, 1'b1, 1'b0);
    for (int c = 0; c < CH; c++) chk("R11", $sformatf("held steady ch%0d", c), heldAt(c), 500 + c);
    chk("R8", "no pulse when idle", int'(xferPulse), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule